// File: doc/BRIEF.md
# DMA Arbiter with Refresh Priority

This block decides which bus master runs next when several DMA channels and a periodic DRAM refresh all want the bus. A timer tick marks a refresh as due. A due refresh wins over every channel. Among the channels, the lowest-numbered requester wins. Arbitration happens only between transfers: once an owner is chosen, it keeps the grant until the transfer engine reports the cycle done.

Any pending request raises a hold request toward the processor. No owner is chosen until the processor's hold acknowledge is seen. During a refresh, the block does four things:
- drives the current refresh row address onto the address output;
- tells the DRAM state machine to ignore chip selects, so that no normal access starts when the refresh ends;
- raises a qualified refresh request, which is the refresh ownership ANDed with hold acknowledge;
- steps the row address by one once the refresh completes, wrapping at the width of the counter.

The DMA transfer engines themselves are outside this block.

Top module: `dma_refresh_arbiter`

## Requirements
- R1: After reset, hold_req, chan_gnt, refresh_qual and cs_ignore are 0 and addr_out is 0. The internal refresh row address starts at 0.
- R2: hold_req rises at the first clock edge at which, with the block idle, a channel request, a refresh tick or a latched refresh is sampled. With no request, hold_req stays 0.
- R3: While hold acknowledge has not been sampled high in the waiting state, no channel grant is given and cs_ignore stays 0.
- R4: At arbitration, a latched refresh wins over every channel request. chan_gnt stays 0 and cs_ignore becomes 1 on the edge after hold acknowledge is sampled.
- R5: With no refresh latched, the lowest-numbered requesting channel wins. chan_gnt is one-hot, with bit i granting channel i.
- R6: The chosen owner holds its grant until xfer_done. Changes on chan_req during a transfer have no effect on chan_gnt.
- R7: refresh_qual equals refresh ownership ANDed with hold_ack, and follows hold_ack with no clock delay. cs_ignore stays 1 for the whole refresh ownership, whatever hold_ack does.
- R8: During refresh ownership, addr_out shows the refresh row address; otherwise it is 0. The row address increments by one after each completed refresh and wraps to 0 after 2^ADDR_W refreshes.
- R9: On the edge that samples xfer_done, the grant outputs clear. If nothing else is pending, hold_req falls on that same edge. Otherwise hold_req stays high and the block arbitrates again.
- R10: Several ticks that arrive before a refresh is served produce a single refresh. A tick sampled together with the xfer_done of a refresh leaves a new refresh pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Per-channel DMA request, bit i for channel i |
| refresh_tick | input | 1 | Periodic timer pulse marking a refresh as due |
| hold_ack | input | 1 | Processor's bus-grant (hold acknowledge) |
| xfer_done | input | 1 | End of the current transfer or refresh cycle |
| hold_req | output | 1 | Bus request to the processor |
| chan_gnt | output | NCH | One-hot channel grant |
| refresh_qual | output | 1 | Refresh request to the DRAM controller, gated by hold_ack |
| addr_out | output | ADDR_W | Refresh row address during refresh, else 0 |
| cs_ignore | output | 1 | Tells the DRAM state machine to ignore chip selects |

## Verification
The assertions take some input behaviour for granted:
- hold_ack stays high for the whole of a channel transfer. Only during refresh ownership may it drop briefly.
- xfer_done is pulsed only while an owner holds the bus.

The bench keeps to these rules. It raises hold_ack only after it sees hold_req. During refresh ownership it drops hold_ack for a single cycle to exercise the gating. It gives every xfer_done as a one-cycle pulse after a grant has appeared. It releases hold_ack only once hold_req has fallen.

The bench sweeps every channel request pattern of a four-channel, four-bit-address configuration, both with and without a refresh. This makes the row address wrap inside the run.

// File: rtl/dra_pkg.sv
package dra_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_BUSY = 2'd2
  } arb_state_t;
endpackage

// File: rtl/dra_refresh_unit.sv
// Latches refresh ticks until served and keeps the refresh row address.
module dra_refresh_unit #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              served,
  output logic              pend,
  output logic [ADDR_W-1:0] row_addr
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      row_addr <= '0;
    end else begin
      // a tick in the serving cycle keeps a fresh refresh pending
      pend <= (pend & ~served) | tick;
      if (served) row_addr <= row_addr + ONE;
    end
  end
endmodule

// File: rtl/dra_lowest_pick.sv
// One-hot pick of the lowest-numbered active request.
module dra_lowest_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req[i];
    assign pick[i]   = req[i] & ~seen[i];
  end

  assign any = seen[N];
endmodule

// File: rtl/dra_ctrl.sv
// Bus ownership sequencer: idle -> wait for hold ack -> busy until done.
module dra_ctrl
  import dra_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rf_pend,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [NCH-1:0]    ch_pick,
  input  logic              ch_any,
  input  logic              hold_ack,
  input  logic              xfer_done,
  output logic              hold_q,
  output logic [NCH-1:0]    gnt_q,
  output logic              rf_own_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rf_served,
  output logic              in_wait
);
  arb_state_t state;
  logic       want;
  logic       more;

  assign want      = rf_pend | tick | ch_any;
  assign rf_served = (state == ARB_BUSY) & rf_own_q & xfer_done;
  // work left after the current owner finishes
  assign more      = (rf_pend & ~rf_own_q) | tick | ch_any;
  assign in_wait   = (state == ARB_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ARB_IDLE;
      hold_q   <= 1'b0;
      gnt_q    <= '0;
      rf_own_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      unique case (state)
        ARB_IDLE: begin
          if (want) begin
            state  <= ARB_WAIT;
            hold_q <= 1'b1;
          end
        end
        ARB_WAIT: begin
          if (hold_ack && rf_pend) begin
            state    <= ARB_BUSY;
            rf_own_q <= 1'b1;
            addr_q   <= rf_addr;
          end else if (hold_ack && ch_any) begin
            state <= ARB_BUSY;
            gnt_q <= ch_pick;
          end else if (!want) begin
            state  <= ARB_IDLE;
            hold_q <= 1'b0;
          end
        end
        ARB_BUSY: begin
          if (xfer_done) begin
            gnt_q    <= '0;
            rf_own_q <= 1'b0;
            addr_q   <= '0;
            if (more) begin
              state <= ARB_WAIT;
            end else begin
              state  <= ARB_IDLE;
              hold_q <= 1'b0;
            end
          end
        end
        default: begin
          state  <= ARB_IDLE;
          hold_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_refresh_arbiter.sv
module dma_refresh_arbiter #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    chan_req,
  input  logic              refresh_tick,
  input  logic              hold_ack,
  input  logic              xfer_done,
  output logic              hold_req,
  output logic [NCH-1:0]    chan_gnt,
  output logic              refresh_qual,
  output logic [ADDR_W-1:0] addr_out,
  output logic              cs_ignore
);
  logic              rf_pend;
  logic [ADDR_W-1:0] rf_addr;
  logic              rf_served;
  logic [NCH-1:0]    ch_pick;
  logic              ch_any;
  logic              rf_own;
  logic              st_wait;

  dra_refresh_unit #(.ADDR_W(ADDR_W)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .tick     (refresh_tick),
    .served   (rf_served),
    .pend     (rf_pend),
    .row_addr (rf_addr)
  );

  dra_lowest_pick #(.N(NCH)) u_pick (
    .req  (chan_req),
    .pick (ch_pick),
    .any  (ch_any)
  );

  dra_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tick      (refresh_tick),
    .rf_pend   (rf_pend),
    .rf_addr   (rf_addr),
    .ch_pick   (ch_pick),
    .ch_any    (ch_any),
    .hold_ack  (hold_ack),
    .xfer_done (xfer_done),
    .hold_q    (hold_req),
    .gnt_q     (chan_gnt),
    .rf_own_q  (rf_own),
    .addr_q    (addr_out),
    .rf_served (rf_served),
    .in_wait   (st_wait)
  );

  assign cs_ignore    = rf_own;
  assign refresh_qual = rf_own & hold_ack;
endmodule

// File: rtl/dra_checker.sv
module dra_checker #(
  parameter int NCH    = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [NCH-1:0]    chan_req,
  input logic              refresh_tick,
  input logic              hold_ack,
  input logic              xfer_done,
  input logic              hold_req,
  input logic [NCH-1:0]    chan_gnt,
  input logic              refresh_qual,
  input logic [ADDR_W-1:0] addr_out,
  input logic              cs_ignore,
  input logic              rf_pend,
  input logic [ADDR_W-1:0] rf_addr,
  input logic              st_wait
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  // R3
  gnt_needs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|chan_gnt || cs_ignore) |-> hold_req);
  // R3
  gnt_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (|chan_gnt) |-> hold_ack);
  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({chan_gnt, cs_ignore}));
  // R4
  refresh_first_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wait && hold_ack && rf_pend) |=> (cs_ignore && chan_gnt == '0));
  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (st_wait && hold_ack && !rf_pend && |chan_req)
      |=> chan_gnt == ($past(chan_req) & (~$past(chan_req) + 1'b1)));
  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (|chan_gnt && !xfer_done) |=> $stable(chan_gnt));
  // R7
  qual_gate_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_qual |-> (cs_ignore && hold_ack));
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_ignore && xfer_done) |=> rf_addr == $past(addr_out) + ONE);
  // R8
  addr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_ignore |-> addr_out == '0);
  // R9
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_done && cs_ignore && chan_req == '0 && !refresh_tick) |=> !hold_req);
endmodule

bind dma_refresh_arbiter dra_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dra_chk (
  .clk          (clk),
  .rst          (rst),
  .chan_req     (chan_req),
  .refresh_tick (refresh_tick),
  .hold_ack     (hold_ack),
  .xfer_done    (xfer_done),
  .hold_req     (hold_req),
  .chan_gnt     (chan_gnt),
  .refresh_qual (refresh_qual),
  .addr_out     (addr_out),
  .cs_ignore    (cs_ignore),
  .rf_pend      (rf_pend),
  .rf_addr      (rf_addr),
  .st_wait      (st_wait)
);

// File: tb/tb_dma_refresh_arbiter.sv
`timescale 1ns/1ps
module tb_dma_refresh_arbiter;
  localparam int NCH    = 4;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst;
  logic [NCH-1:0]    chan_req;
  logic              refresh_tick;
  logic              hold_ack;
  logic              xfer_done;
  logic              hold_req;
  logic [NCH-1:0]    chan_gnt;
  logic              refresh_qual;
  logic [ADDR_W-1:0] addr_out;
  logic              cs_ignore;

  int errors = 0;
  int checks = 0;
  int ref_count = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dma_refresh_arbiter #(.NCH(NCH), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .chan_req(chan_req), .refresh_tick(refresh_tick),
    .hold_ack(hold_ack), .xfer_done(xfer_done), .hold_req(hold_req),
    .chan_gnt(chan_gnt), .refresh_qual(refresh_qual), .addr_out(addr_out),
    .cs_ignore(cs_ignore)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] lowest(input logic [NCH-1:0] r);
    for (int i = 0; i < NCH; i++) if (r[i]) return NCH'(1) << i;
    return '0;
  endfunction

  function automatic int exp_addr();
    return ref_count % (1 << ADDR_W);
  endfunction

  // one arbitrated transfer, optionally with a refresh competing
  task automatic run_xfer(input logic [NCH-1:0] r, input bit f);
    logic [NCH-1:0] g;
    @(negedge clk); chan_req = r; refresh_tick = f;
    @(negedge clk); refresh_tick = 1'b0;
    chk(hold_req == 1'b1, "R2", "hold_req after request", int'(hold_req), 1);
    chk(chan_gnt == '0 && !cs_ignore, "R3", "grant before ack", int'(chan_gnt), 0);
    @(negedge clk);
    chk(chan_gnt == '0 && !cs_ignore, "R3", "grant still withheld", int'(chan_gnt), 0);
    hold_ack = 1'b1;
    @(negedge clk);
    if (f) begin
      chk(cs_ignore == 1'b1, "R4", "refresh owns bus", int'(cs_ignore), 1);
      chk(chan_gnt == '0, "R4", "no channel grant beside refresh", int'(chan_gnt), 0);
      chk(int'(addr_out) == exp_addr(), "R8", "refresh address", int'(addr_out), exp_addr());
      chk(refresh_qual == 1'b1, "R7", "qualified refresh", int'(refresh_qual), 1);
    end else begin
      chk(chan_gnt == lowest(r), "R5", "lowest channel", int'(chan_gnt), int'(lowest(r)));
      chk(addr_out == '0, "R8", "address idle on channel grant", int'(addr_out), 0);
    end
    g = chan_gnt;
    chan_req = ~r;
    @(negedge clk);
    chk(chan_gnt == g, "R6", "grant ignores request change", int'(chan_gnt), int'(g));
    if (f) hold_ack = 1'b0;
    @(negedge clk);
    if (f) begin
      chk(refresh_qual == 1'b0, "R7", "qual follows ack low", int'(refresh_qual), 0);
      chk(cs_ignore == 1'b1, "R7", "cs_ignore held", int'(cs_ignore), 1);
      hold_ack = 1'b1;
    end
    xfer_done = 1'b1;
    chan_req = f ? r : '0;
    @(negedge clk);
    xfer_done = 1'b0;
    if (f) ref_count++;
    chk(chan_gnt == '0 && !cs_ignore, "R9", "grants cleared at done", int'(chan_gnt), 0);
    if (f && r != '0) begin
      chk(hold_req == 1'b1, "R9", "hold kept for pending channel", int'(hold_req), 1);
      @(negedge clk);
      chk(chan_gnt == lowest(r), "R5", "channel after refresh", int'(chan_gnt), int'(lowest(r)));
      xfer_done = 1'b1; chan_req = '0;
      @(negedge clk);
      xfer_done = 1'b0;
    end
    chk(hold_req == 1'b0, "R9", "hold drops when idle", int'(hold_req), 0);
    chk(addr_out == '0, "R8", "address cleared after transfer", int'(addr_out), 0);
    hold_ack = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; chan_req = '0; refresh_tick = 1'b0; hold_ack = 1'b0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!hold_req && chan_gnt == '0 && !refresh_qual && !cs_ignore && addr_out == '0,
        "R1", "reset outputs", int'(hold_req), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(hold_req == 1'b0, "R2", "no request no hold", int'(hold_req), 0);

    // sweep all patterns, with and without refresh; 16 refreshes wrap the address
    for (int f = 0; f < 2; f++)
      for (int r = 0; r < (1 << NCH); r++)
        if (r != 0 || f != 0) run_xfer(NCH'(r), f[0]);
    chk(exp_addr() == 0, "R8", "address wrapped", exp_addr(), 0);

    // R10: several ticks coalesce into one refresh
    @(negedge clk); refresh_tick = 1'b1;
    @(negedge clk); refresh_tick = 1'b0;
    @(negedge clk); refresh_tick = 1'b1;
    @(negedge clk); refresh_tick = 1'b1;
    @(negedge clk); refresh_tick = 1'b0; hold_ack = 1'b1;
    @(negedge clk);
    chk(cs_ignore == 1'b1, "R10", "coalesced refresh granted", int'(cs_ignore), 1);
    chk(int'(addr_out) == exp_addr(), "R10", "coalesced address", int'(addr_out), exp_addr());
    xfer_done = 1'b1; refresh_tick = 1'b1;   // tick with done keeps one pending
    @(negedge clk);
    xfer_done = 1'b0; refresh_tick = 1'b0; ref_count++;
    chk(hold_req == 1'b1, "R10", "tick at done keeps hold", int'(hold_req), 1);
    @(negedge clk);
    chk(cs_ignore == 1'b1, "R10", "second refresh granted", int'(cs_ignore), 1);
    chk(int'(addr_out) == exp_addr(), "R8", "incremented address", int'(addr_out), exp_addr());
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0; ref_count++;
    chk(hold_req == 1'b0, "R10", "only one extra refresh", int'(hold_req), 0);
    hold_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk(hold_req == 1'b0 && !cs_ignore, "R10", "no stale refresh", int'(cs_ignore), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule